// File: doc/BRIEF.md
# Compare-And-Jump Condition Unit

This unit resolves conditional jumps for a 32-bit core. It receives one decoded instruction word per cycle, together with the value of the first source register, the value of a second register, the jump-address register and the current instruction pointer. The unit decides whether the jump is taken and produces the next instruction pointer. It supports two jump encodings. The register form compares two registers. The immediate form compares one register with a 16-bit constant, which is sign-extended to the datapath width before the compare.

A 4-bit condition field selects the test: always, equal, not equal, unsigned greater-than or greater-or-equal, and signed greater-than or greater-or-equal. A taken jump always goes to the address held in the dedicated jump register. Any other outcome moves the pointer on by one word. Condition codes that are not defined are never taken and are flagged. The result is registered, so outputs appear one clock after the request.

Top module: `cj_unit`

## Requirements
- R1: While `rst` is high, and on the first output cycle after it, `res_valid`, `res_jump`, `res_taken` and `res_badcc` are 0 and `res_next_ip` is 0.
- R2: With default parameters, opcode 0x40 in bits [31:24] is the register form. The condition is in bits [23:20]. The second compare operand is `op_b_reg`, and bits [11:0] are ignored.
- R3: Opcode 0x41 is the immediate form. The second operand is bits [15:0] of the word, sign-extended to 32 bits, and `op_b_reg` is ignored.
- R4: Condition 0x0 is always taken. Condition 0x1 is taken when the operands differ. Condition 0x2 is taken when they are equal.
- R5: Condition 0x3 is taken when A > B (unsigned). Condition 0x4 is taken when A >= B (unsigned).
- R6: Condition 0xC is taken when A > B (two's complement). Condition 0xD is taken when A >= B (two's complement).
- R7: Conditions 0x5 to 0xB, 0xE and 0xF are never taken, and they set `res_badcc` on a jump opcode.
- R8: When a jump is taken, `res_next_ip` equals the `jump_reg` value presented with the request.
- R9: When a jump is not taken, `res_next_ip` is `cur_ip` + 1, wrapping at 2^32.
- R10: Any other opcode gives `res_jump`=0, `res_taken`=0, `res_badcc`=0 and `res_next_ip` = `cur_ip` + 1.
- R11: Results appear on the outputs exactly one clock after `req_valid` is sampled high. A cycle with `req_valid` low gives `res_valid`=0 and clears all flags, and `res_next_ip` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| instr | input | 32 | Instruction word |
| op_a | input | 32 | First source register value |
| op_b_reg | input | 32 | Second source register value (register form) |
| jump_reg | input | 32 | Jump-address register contents |
| cur_ip | input | 32 | Current instruction pointer |
| res_valid | output | 1 | Result valid |
| res_jump | output | 1 | The word was a compare-and-jump |
| res_taken | output | 1 | The jump is taken |
| res_badcc | output | 1 | Undefined condition code |
| res_next_ip | output | 32 | Next instruction pointer |

## Verification
A wrong operand select or a wrong sign-extension shows up as a flipped `res_taken` on the result cycle right after the request. An immediate with bit 15 set, compared against a register near the signed boundary, exposes this most clearly. A swapped signed or unsigned compare appears on the same cycle only when the operands straddle 0x80000000, so those operand pairs are driven directly. A stale or misrouted target shows on `res_next_ip` in the result cycle. A wrong held value after an idle cycle appears one clock later.

// File: rtl/cj_pkg.sv
package cj_pkg;

    // Fixed instruction format field positions
    localparam int OPC_W   = 8;
    localparam int CC_W    = 4;
    localparam int REG_W   = 4;
    localparam int IMM_W   = 16;
    localparam int OPC_LSB = 24;
    localparam int CC_LSB  = 20;
    localparam int RA_LSB  = 16;
    localparam int RB_LSB  = 12;

    typedef enum logic [CC_W-1:0] {
        CC_ALWAYS = 4'h0,
        CC_NE     = 4'h1,
        CC_EQ     = 4'h2,
        CC_UGT    = 4'h3,
        CC_UGE    = 4'h4,
        CC_SGT    = 4'hC,
        CC_SGE    = 4'hD
    } cc_e;

    typedef enum logic [1:0] {
        FORM_NONE = 2'd0,
        FORM_REG  = 2'd1,
        FORM_IMM  = 2'd2
    } form_e;

    // Relations between operand A and operand B
    typedef struct packed {
        logic eq;
        logic ugt;
        logic sgt;
    } rel_t;

    typedef struct packed {
        form_e             form;
        logic [CC_W-1:0]   cc;
        logic [IMM_W-1:0]  imm;
    } dec_t;

    function automatic logic cc_defined(input logic [CC_W-1:0] c);
        case (c)
            CC_ALWAYS, CC_NE, CC_EQ, CC_UGT, CC_UGE, CC_SGT, CC_SGE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic cc_eval(input logic [CC_W-1:0] c, input rel_t r);
        case (c)
            CC_ALWAYS: return 1'b1;
            CC_NE:     return !r.eq;
            CC_EQ:     return r.eq;
            CC_UGT:    return r.ugt;
            CC_UGE:    return r.ugt | r.eq;
            CC_SGT:    return r.sgt;
            CC_SGE:    return r.sgt | r.eq;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cj_decode.sv
module cj_decode
    import cj_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter logic [OPC_W-1:0] OPC_REG = 8'h40,
    parameter logic [OPC_W-1:0] OPC_IMM = 8'h41
) (
    input  logic [DATA_W-1:0] instr,
    input  logic [DATA_W-1:0] op_b_reg,
    output dec_t              dec,
    output logic [DATA_W-1:0] op_b
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [OPC_W-1:0] opc;
    logic [IMM_W-1:0] imm;

    assign opc = instr[OPC_LSB +: OPC_W];
    assign imm = instr[IMM_W-1:0];

    always_comb begin
        dec.cc  = instr[CC_LSB +: CC_W];
        dec.imm = imm;
        if (opc == OPC_REG)      dec.form = FORM_REG;
        else if (opc == OPC_IMM) dec.form = FORM_IMM;
        else                     dec.form = FORM_NONE;
    end

    always_comb begin
        if (dec.form == FORM_IMM) op_b = {{EXT_W{imm[IMM_W-1]}}, imm};
        else                      op_b = op_b_reg;
    end

endmodule

// File: rtl/cj_compare.sv
module cj_compare
    import cj_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output rel_t              rel
);
    assign rel.eq  = (a == b);
    assign rel.ugt = (a > b);
    assign rel.sgt = ($signed(a) > $signed(b));
endmodule

// File: rtl/cj_cond.sv
module cj_cond
    import cj_pkg::*;
(
    input  form_e           form,
    input  logic [CC_W-1:0] cc,
    input  rel_t            rel,
    output logic            is_jump,
    output logic            taken,
    output logic            badcc
);
    always_comb begin
        is_jump = (form != FORM_NONE);
        badcc   = is_jump && !cc_defined(cc);
        taken   = is_jump && cc_eval(cc, rel);
    end
endmodule

// File: rtl/cj_unit.sv
module cj_unit
    import cj_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter logic [OPC_W-1:0] OPC_REG = 8'h40,
    parameter logic [OPC_W-1:0] OPC_IMM = 8'h41,
    parameter int IP_STEP = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] instr,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b_reg,
    input  logic [DATA_W-1:0] jump_reg,
    input  logic [DATA_W-1:0] cur_ip,
    output logic              res_valid,
    output logic              res_jump,
    output logic              res_taken,
    output logic              res_badcc,
    output logic [DATA_W-1:0] res_next_ip
);
    localparam logic [DATA_W-1:0] STEP = DATA_W'(IP_STEP);

    dec_t              dec;
    logic [DATA_W-1:0] op_b;
    rel_t              rel;
    logic              c_jump, c_taken, c_bad;
    logic [DATA_W-1:0] seq_ip;

    cj_decode #(.DATA_W(DATA_W), .OPC_REG(OPC_REG), .OPC_IMM(OPC_IMM)) u_dec (
        .instr(instr), .op_b_reg(op_b_reg), .dec(dec), .op_b(op_b)
    );

    cj_compare #(.DATA_W(DATA_W)) u_cmp (
        .a(op_a), .b(op_b), .rel(rel)
    );

    cj_cond u_cond (
        .form(dec.form), .cc(dec.cc), .rel(rel),
        .is_jump(c_jump), .taken(c_taken), .badcc(c_bad)
    );

    assign seq_ip = cur_ip + STEP;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_jump    <= 1'b0;
            res_taken   <= 1'b0;
            res_badcc   <= 1'b0;
            res_next_ip <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_jump    <= c_jump;
                res_taken   <= c_taken;
                res_badcc   <= c_bad;
                res_next_ip <= c_taken ? jump_reg : seq_ip;
            end else begin
                res_jump  <= 1'b0;
                res_taken <= 1'b0;
                res_badcc <= 1'b0;
            end
        end
    end

    // Taken jumps load the jump register seen one cycle earlier
    assert_taken_target_R8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_taken) |-> (res_next_ip == $past(jump_reg)));

    // Fall-through advances by one word
    assert_seq_ip_R9: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_taken) |-> (res_next_ip == $past(cur_ip) + STEP));

    // Undefined condition codes never redirect
    assert_bad_not_taken_R7: assert property (@(posedge clk) disable iff (rst)
        res_badcc |-> (!res_taken && res_jump));

    // Idle cycles are quiet and keep the pointer
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!res_valid && !res_taken && !res_badcc && !res_jump
                        && $stable(res_next_ip)));

    // Non-jump opcodes do nothing but step
    assert_nonjump_R10: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_jump) |-> (!res_taken && !res_badcc));

    // Always-taken code redirects regardless of operands
    assert_always_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (instr[OPC_LSB +: OPC_W] == OPC_REG || instr[OPC_LSB +: OPC_W] == OPC_IMM)
         && instr[CC_LSB +: CC_W] == CC_ALWAYS) |=> res_taken);

endmodule

// File: tb/cj_unit_test.sv
`timescale 1ns/1ps
module cj_unit_test;

    localparam logic [7:0] OPR = 8'h40;
    localparam logic [7:0] OPI = 8'h41;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] instr = '0, op_a = '0, op_b_reg = '0, jump_reg = '0, cur_ip = '0;
    logic        res_valid, res_jump, res_taken, res_badcc;
    logic [31:0] res_next_ip;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cj_unit uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .instr(instr),
        .op_a(op_a), .op_b_reg(op_b_reg), .jump_reg(jump_reg), .cur_ip(cur_ip),
        .res_valid(res_valid), .res_jump(res_jump), .res_taken(res_taken),
        .res_badcc(res_badcc), .res_next_ip(res_next_ip)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_r(input logic [3:0] cc, input logic [31:0] junk);
        return {OPR, cc, 4'h1, 4'h2, junk[11:0]};
    endfunction

    function automatic logic [31:0] mk_i(input logic [3:0] cc, input logic [15:0] imm);
        return {OPI, cc, 4'h3, imm};
    endfunction

    function automatic void model(input logic [31:0] ins, a, rb, jr, ip,
                                  output logic jp, output logic tk, output logic bd,
                                  output logic [31:0] nip);
        logic [31:0] b;
        logic [3:0]  cc;
        cc = ins[23:20];
        b  = (ins[31:24] == OPI) ? {{16{ins[15]}}, ins[15:0]} : rb;
        jp = (ins[31:24] == OPR) || (ins[31:24] == OPI);
        tk = 1'b0;
        bd = 1'b0;
        if (jp) begin
            case (cc)
                4'h0: tk = 1'b1;
                4'h1: tk = (a != b);
                4'h2: tk = (a == b);
                4'h3: tk = (a > b);
                4'h4: tk = (a >= b);
                4'hC: tk = ($signed(a) > $signed(b));
                4'hD: tk = ($signed(a) >= $signed(b));
                default: bd = 1'b1;
            endcase
        end
        nip = tk ? jr : ip + 32'd1;
    endfunction

    task automatic run(input string req, input logic [31:0] ins, a, rb, jr, ip);
        logic jp, tk, bd;
        logic [31:0] nip;
        model(ins, a, rb, jr, ip, jp, tk, bd, nip);
        @(negedge clk);
        req_valid = 1'b1; instr = ins; op_a = a; op_b_reg = rb; jump_reg = jr; cur_ip = ip;
        @(negedge clk);
        req_valid = 1'b0;
        instr = 32'hFFFF_FFFF; jump_reg = ~jr; cur_ip = ~ip;
        chk({req, " valid"}, {31'd0, res_valid}, 32'd1);
        chk({req, " jump"},  {31'd0, res_jump},  {31'd0, jp});
        chk({req, " taken"}, {31'd0, res_taken}, {31'd0, tk});
        chk({req, " badcc"}, {31'd0, res_badcc}, {31'd0, bd});
        chk({req, " nextip"}, res_next_ip, nip);
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [31:0] hold;
        void'($urandom(32'd20240613));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 valid", {31'd0, res_valid}, 32'd0);
        chk("R1 taken", {31'd0, res_taken}, 32'd0);
        chk("R1 nextip", res_next_ip, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 post valid", {31'd0, res_valid}, 32'd0);
        chk("R1 post badcc", {31'd0, res_badcc}, 32'd0);

        // R2: register form, low bits ignored
        run("R2 eq junk", mk_r(4'h2, 32'hFFF), 32'd5, 32'd5, 32'h100, 32'h10);
        run("R2 ne", mk_r(4'h2, 32'h0), 32'd5, 32'd6, 32'h100, 32'h10);
        // R3: immediate form, sign extension, op_b_reg ignored
        run("R3 sext eq", mk_i(4'h2, 16'h8000), 32'hFFFF_8000, 32'h0, 32'h200, 32'h20);
        run("R3 sgt", mk_i(4'hC, 16'hFFFF), 32'h0, 32'h7FFF_FFFF, 32'h200, 32'h20);
        run("R3 ugt", mk_i(4'h3, 16'hFFFF), 32'hFFFF_FFFE, 32'h0, 32'h200, 32'h20);
        // R4
        run("R4 always", mk_r(4'h0, 0), 32'd1, 32'd9, 32'h300, 32'h30);
        run("R4 ne", mk_r(4'h1, 0), 32'd1, 32'd9, 32'h300, 32'h30);
        run("R4 ne same", mk_r(4'h1, 0), 32'd9, 32'd9, 32'h300, 32'h30);
        // R5 / R6 at the signed boundary
        run("R5 ugt", mk_r(4'h3, 0), 32'h8000_0000, 32'h7FFF_FFFF, 32'h400, 32'h40);
        run("R5 uge eq", mk_r(4'h4, 0), 32'h8000_0000, 32'h8000_0000, 32'h400, 32'h40);
        run("R6 sgt", mk_r(4'hC, 0), 32'h8000_0000, 32'h7FFF_FFFF, 32'h400, 32'h40);
        run("R6 sge eq", mk_r(4'hD, 0), 32'h8000_0000, 32'h8000_0000, 32'h400, 32'h40);
        run("R6 sge lt", mk_r(4'hD, 0), 32'hFFFF_FFFF, 32'h0, 32'h400, 32'h40);
        // R7
        run("R7 cc5", mk_r(4'h5, 0), 32'd3, 32'd3, 32'h500, 32'h50);
        run("R7 ccF", mk_i(4'hF, 16'h1), 32'd3, 32'd3, 32'h500, 32'h50);
        // R8 / R9 with wrap
        run("R8 target", mk_i(4'h0, 16'h0), 32'd0, 32'd0, 32'hDEAD_BEEF, 32'h60);
        run("R9 wrap", mk_r(4'h2, 0), 32'd1, 32'd2, 32'h600, 32'hFFFF_FFFF);
        // R10
        run("R10 other", {8'h42, 4'h0, 20'h0}, 32'd0, 32'd0, 32'h700, 32'h70);
        run("R10 zero", 32'h0, 32'd0, 32'd0, 32'h700, 32'h71);
        // R11: idle cycle holds next IP and clears flags
        run("R11 setup", mk_r(4'h0, 0), 32'd0, 32'd0, 32'h1234, 32'h80);
        hold = res_next_ip;
        @(negedge clk);
        chk("R11 idle valid", {31'd0, res_valid}, 32'd0);
        chk("R11 idle taken", {31'd0, res_taken}, 32'd0);
        chk("R11 idle hold", res_next_ip, hold);

        // Random mix
        for (int i = 0; i < 500; i++) begin
            logic [31:0] w, a, b;
            logic [3:0]  cc;
            int sel;
            cc  = 4'($urandom_range(15));
            sel = int'($urandom_range(9));
            a   = $urandom;
            b   = $urandom;
            if (sel < 4) begin
                if ($urandom_range(3) == 0) b = a;
                w = mk_r(cc, $urandom);
            end else if (sel < 8) begin
                w = mk_i(cc, 16'($urandom));
                if ($urandom_range(3) == 0) a = {{16{w[15]}}, w[15:0]};
            end else begin
                w = $urandom;
            end
            run("RND", w, a, b, $urandom, $urandom);
        end
        finish_up();
    end

endmodule